// File: doc/BRIEF.md
# Parity Error Burst Marker

The marker sits in a packet-interface receiver just after the per-control-word parity check. Traffic arrives as bursts of data beats. Each burst is bounded by control words. The control word that opens a burst carries its port number and a start-of-packet flag. The control word that closes it carries the end-of-packet flag and the parity verdict for the beats that came before it. The marker sends the same beats on to the FIFO write side. On the last beat of every burst it adds a single error sideband bit.

The policy comes from a static mode input. Under the lenient policy, a parity failure blames the bursts next to the failing control word. Under the strict policy, it blames every packet that is open on any port at that moment. A third setting never blames anything. The block holds back the newest beat by one event, so that a burst's error bit can wait for the parity result of the control word that closes it.

Top module: `epm_marker`

## Requirements
- R1: `mode_i` selects the policy: 0 = off, 1 = optimistic, 2 = pessimistic, 3 behaves as off. When off, `out_err_o` is never set.
- R2: Each data beat is emitted one cycle after the next input event, which is either a data beat or a control word. A beat released by a control word carries `out_eob_o`=1 and `out_eop_o` equal to that word's `ctl_eop_i`. A beat released by another data beat carries `out_eob_o`=0.
- R3: Every beat carries the port given by the control word that opened its burst. `out_sop_o` is 1 only on the first beat of a burst opened with `ctl_sop_i`=1.
- R4: In optimistic mode, a control word with `ctl_perr_i`=1 flags the burst that it closes.
- R5: In optimistic mode, a control word with `ctl_perr_i`=1 and `ctl_next_i`=1 also flags the burst that follows it.
- R6: In optimistic mode, an errored control word with `ctl_next_i`=0 (idles follow) flags only the preceding burst. The next burst, opened by a later clean control word, is unflagged.
- R7: In pessimistic mode, a parity error flags every packet that is open on any port when the error arrives. This includes the packet of the burst being closed. Every remaining burst of such a packet is flagged, up to and including its EOP burst.
- R8: In pessimistic mode, a packet that starts at or after the errored control word is not flagged. Neither is a port's next packet after the flagged packet's EOP.
- R9: The error bit appears only on end-of-burst beats. A flagged burst without EOP gets no further packet-level action: in optimistic mode, later clean bursts of the same packet are unflagged.
- R10: A control word that arrives while no beat is held produces no output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Marking policy (static) |
| ctl_i | input | 1 | Control word present this cycle |
| ctl_perr_i | input | 1 | Parity mismatch reported with this control word |
| ctl_next_i | input | 1 | A burst follows this control word (0 = idles) |
| ctl_sop_i | input | 1 | Following burst starts a packet |
| ctl_eop_i | input | 1 | Preceding burst ends its packet |
| ctl_port_i | input | PORT_W | Port of the following burst |
| dat_vld_i | input | 1 | Data beat present (never together with ctl_i) |
| dat_i | input | DATA_W | Data beat |
| out_vld_o | output | 1 | Output beat valid |
| out_dat_o | output | DATA_W | Output beat data |
| out_port_o | output | PORT_W | Port of the output beat |
| out_sop_o | output | 1 | First beat of a packet |
| out_eob_o | output | 1 | Last beat of a burst |
| out_eop_o | output | 1 | Last beat of a packet |
| out_err_o | output | 1 | Burst flagged as errored |

## Verification
A beat is due exactly one cycle after the input event that follows it, never earlier. The error bit therefore shows up one cycle after the closing control word, on the beat that word releases. The bench derives each expected beat at the moment the releasing event is driven and queues it. The monitor compares each output beat against the queue on the falling edge after it appears. Any output beat that arrives with nothing queued is a failure, and so is any expectation still queued at the end.

// File: rtl/epm_pkg.sv
package epm_pkg;
  typedef enum logic [1:0] {
    MARK_OFF  = 2'd0,
    MARK_OPT  = 2'd1,
    MARK_PESS = 2'd2
  } mark_mode_e;
endpackage

// File: rtl/epm_open_tracker.sv
module epm_open_tracker #(
  parameter int NPORTS = 16,
  localparam int PORT_W = $clog2(NPORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              taint_i,
  input  logic              cls_eop_i,
  input  logic [PORT_W-1:0] cls_port_i,
  input  logic              new_sop_i,
  input  logic [PORT_W-1:0] new_port_i,
  output logic [NPORTS-1:0] open_o,
  output logic [NPORTS-1:0] sticky_o
);
  logic [NPORTS-1:0] open_q, sticky_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic clr, set;
    assign clr = cls_eop_i && (cls_port_i == PORT_W'(p));
    assign set = new_sop_i && (new_port_i == PORT_W'(p));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[p]   <= 1'b0;
        sticky_q[p] <= 1'b0;
      end else begin
        open_q[p]   <= (open_q[p] && !clr) || set;
        sticky_q[p] <= (sticky_q[p] || (taint_i && open_q[p])) && !clr && !set;
      end
    end
  end

  assign open_o   = open_q;
  assign sticky_o = sticky_q;

  // a sticky mark can only live on an open packet
  assert_sticky_in_open_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_q & ~open_q) == '0);
endmodule

// File: rtl/epm_hold_stage.sv
module epm_hold_stage #(
  parameter int DATA_W = 32,
  parameter int PORT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] cap_dat_i,
  input  logic [PORT_W-1:0] cap_port_i,
  input  logic              cap_sop_i,
  input  logic              close_i,
  input  logic              close_eop_i,
  input  logic              close_err_i,
  output logic              held_vld_o,
  output logic [PORT_W-1:0] held_port_o,
  output logic              out_vld_o,
  output logic [DATA_W-1:0] out_dat_o,
  output logic [PORT_W-1:0] out_port_o,
  output logic              out_sop_o,
  output logic              out_eob_o,
  output logic              out_eop_o,
  output logic              out_err_o
);
  logic              held_vld_q, held_sop_q;
  logic [DATA_W-1:0] held_dat_q;
  logic [PORT_W-1:0] held_port_q;
  logic              emit;

  assign emit = held_vld_q && (cap_i || close_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_vld_q  <= 1'b0;
      held_sop_q  <= 1'b0;
      held_dat_q  <= '0;
      held_port_q <= '0;
    end else if (cap_i) begin
      held_vld_q  <= 1'b1;
      held_sop_q  <= cap_sop_i;
      held_dat_q  <= cap_dat_i;
      held_port_q <= cap_port_i;
    end else if (close_i) begin
      held_vld_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o  <= 1'b0;
      out_dat_o  <= '0;
      out_port_o <= '0;
      out_sop_o  <= 1'b0;
      out_eob_o  <= 1'b0;
      out_eop_o  <= 1'b0;
      out_err_o  <= 1'b0;
    end else begin
      out_vld_o  <= emit;
      out_dat_o  <= held_dat_q;
      out_port_o <= held_port_q;
      out_sop_o  <= emit && held_sop_q;
      out_eob_o  <= emit && close_i;
      out_eop_o  <= emit && close_i && close_eop_i;
      out_err_o  <= emit && close_i && close_err_i;
    end
  end

  assign held_vld_o  = held_vld_q;
  assign held_port_o = held_port_q;

  assert_err_on_eob_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_err_o |-> (out_eob_o && out_vld_o));
  assert_close_emits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_i && held_vld_q) |=> (out_vld_o && out_eob_o));
  assert_no_ghost_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !held_vld_q |=> !out_vld_o);
endmodule

// File: rtl/epm_err_policy.sv
module epm_err_policy
  import epm_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       perr_i,
  input  logic       carry_i,
  input  logic       open_i,
  input  logic       sticky_i,
  output logic       err_o
);
  always_comb begin
    unique case (mode_i)
      MARK_OPT:  err_o = perr_i || carry_i;
      MARK_PESS: err_o = sticky_i || (perr_i && open_i);
      default:   err_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/epm_marker.sv
module epm_marker
  import epm_pkg::*;
#(
  parameter int NPORTS = 16,
  parameter int DATA_W = 32,
  localparam int PORT_W = $clog2(NPORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              ctl_i,
  input  logic              ctl_perr_i,
  input  logic              ctl_next_i,
  input  logic              ctl_sop_i,
  input  logic              ctl_eop_i,
  input  logic [PORT_W-1:0] ctl_port_i,
  input  logic              dat_vld_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic              out_vld_o,
  output logic [DATA_W-1:0] out_dat_o,
  output logic [PORT_W-1:0] out_port_o,
  output logic              out_sop_o,
  output logic              out_eob_o,
  output logic              out_eop_o,
  output logic              out_err_o
);
  logic              cap;
  logic [PORT_W-1:0] cur_port_q;
  logic              cur_first_q, cur_sop_q, carry_q;
  logic              held_vld;
  logic [PORT_W-1:0] held_port;
  logic [NPORTS-1:0] open_vec, sticky_vec;
  logic              close_err;

  assign cap = dat_vld_i && !ctl_i;

  // burst context from the opening control word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_port_q  <= '0;
      cur_first_q <= 1'b0;
      cur_sop_q   <= 1'b0;
      carry_q     <= 1'b0;
    end else if (ctl_i) begin
      cur_port_q  <= ctl_port_i;
      cur_first_q <= ctl_next_i;
      cur_sop_q   <= ctl_next_i && ctl_sop_i;
      carry_q     <= (mode_i == MARK_OPT) && ctl_perr_i && ctl_next_i;
    end else if (cap) begin
      cur_first_q <= 1'b0;
    end
  end

  epm_open_tracker #(.NPORTS(NPORTS)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .taint_i    (ctl_i && ctl_perr_i && (mode_i == MARK_PESS)),
    .cls_eop_i  (ctl_i && ctl_eop_i && held_vld),
    .cls_port_i (held_port),
    .new_sop_i  (ctl_i && ctl_next_i && ctl_sop_i),
    .new_port_i (ctl_port_i),
    .open_o     (open_vec),
    .sticky_o   (sticky_vec)
  );

  epm_err_policy u_pol (
    .mode_i   (mode_i),
    .perr_i   (ctl_perr_i),
    .carry_i  (carry_q),
    .open_i   (open_vec[held_port]),
    .sticky_i (sticky_vec[held_port]),
    .err_o    (close_err)
  );

  epm_hold_stage #(.DATA_W(DATA_W), .PORT_W(PORT_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (cap),
    .cap_dat_i   (dat_i),
    .cap_port_i  (cur_port_q),
    .cap_sop_i   (cur_first_q && cur_sop_q),
    .close_i     (ctl_i),
    .close_eop_i (ctl_eop_i),
    .close_err_i (close_err),
    .held_vld_o  (held_vld),
    .held_port_o (held_port),
    .out_vld_o   (out_vld_o),
    .out_dat_o   (out_dat_o),
    .out_port_o  (out_port_o),
    .out_sop_o   (out_sop_o),
    .out_eob_o   (out_eob_o),
    .out_eop_o   (out_eop_o),
    .out_err_o   (out_err_o)
  );

  assert_off_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o && ($past(mode_i) != MARK_OPT) && ($past(mode_i) != MARK_PESS)) |-> !out_err_o);
  assert_idle_drops_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i && !ctl_next_i) |=> !carry_q);
endmodule

// File: tb/epm_marker_test.sv
module epm_marker_test;
  localparam int NPORTS = 16;
  localparam int DATA_W = 32;
  localparam int PORT_W = $clog2(NPORTS);

  typedef struct packed {
    logic [DATA_W-1:0] dat;
    logic [PORT_W-1:0] port;
    logic sop, eob, eop, err;
  } beat_t;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 2'd0;
  logic ctl = 0, perr = 0, nxt = 0, csop = 0, ceop = 0;
  logic [PORT_W-1:0] cport = '0;
  logic dvld = 0;
  logic [DATA_W-1:0] dat = '0;
  logic out_vld, out_sop, out_eob, out_eop, out_err;
  logic [DATA_W-1:0] out_dat;
  logic [PORT_W-1:0] out_port;

  int checks = 0, failures = 0;
  bit done = 0;
  beat_t exp_q[$];
  string req_q[$];

  // bench-side view of the held beat
  bit pend_vld = 0;
  beat_t pend;
  string pend_req;
  logic [PORT_W-1:0] b_port;
  bit b_first, b_sop;

  always #5 clk = ~clk;

  epm_marker #(.NPORTS(NPORTS), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode),
    .ctl_i(ctl), .ctl_perr_i(perr), .ctl_next_i(nxt), .ctl_sop_i(csop),
    .ctl_eop_i(ceop), .ctl_port_i(cport), .dat_vld_i(dvld), .dat_i(dat),
    .out_vld_o(out_vld), .out_dat_o(out_dat), .out_port_o(out_port),
    .out_sop_o(out_sop), .out_eob_o(out_eob), .out_eop_o(out_eop), .out_err_o(out_err)
  );

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      ctl = 0; dvld = 0;
    end
  endtask

  task automatic do_reset(logic [1:0] m);
    @(posedge clk); #1;
    ctl = 0; dvld = 0; rst_n = 0; mode = m;
    pend_vld = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic send_beat(logic [DATA_W-1:0] d, string req);
    @(posedge clk); #1;
    ctl = 0; dvld = 1; dat = d;
    if (pend_vld) begin
      pend.eob = 0; pend.eop = 0; pend.err = 0;
      exp_q.push_back(pend); req_q.push_back({pend_req, "/R2"});
    end
    pend = '{dat: d, port: b_port, sop: b_first && b_sop, eob: 0, eop: 0, err: 0};
    pend_req = req;
    pend_vld = 1;
    b_first = 0;
  endtask

  task automatic send_ctl(logic pe, logic nx, logic sp, logic [PORT_W-1:0] pt,
                          logic ep, logic exp_err, string req);
    @(posedge clk); #1;
    dvld = 0; ctl = 1; perr = pe; nxt = nx; csop = sp; cport = pt; ceop = ep;
    if (pend_vld) begin
      pend.eob = 1; pend.eop = ep; pend.err = exp_err;
      exp_q.push_back(pend); req_q.push_back(req);
    end
    pend_vld = 0;
    b_port = pt; b_first = nx; b_sop = sp;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      beat_t got, e;
      string r;
      got = '{dat: out_dat, port: out_port, sop: out_sop, eob: out_eob, eop: out_eop, err: out_err};
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R10 unexpected beat actual=%h expected=none", got);
      end else begin
        e = exp_q.pop_front(); r = req_q.pop_front();
        if (got !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", r, got, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // off mode (R1)
    do_reset(2'd0);
    @(negedge clk);
    checks++;
    if (out_vld !== 1'b0 || out_err !== 1'b0) begin
      failures++;
      $display("FAIL reset actual=%b%b expected=00", out_vld, out_err);
    end
    send_ctl(1, 1, 1, 4'd3, 0, 0, "R3");
    send_beat(32'hA0, "R3");
    send_beat(32'hA1, "R1");
    send_ctl(1, 0, 0, 4'd0, 1, 0, "R1");
    send_ctl(0, 0, 0, 4'd0, 0, 0, "R10");
    idle(3);

    // mode 3 behaves as off (R1)
    do_reset(2'd3);
    send_ctl(0, 1, 1, 4'd6, 0, 0, "R1");
    send_beat(32'hB0, "R1");
    send_ctl(1, 0, 0, 4'd0, 1, 0, "R1");
    idle(3);

    // optimistic
    do_reset(2'd1);
    send_ctl(0, 1, 1, 4'd1, 0, 0, "R3");
    send_beat(32'h10, "R9");
    send_beat(32'h11, "R4");
    send_ctl(1, 1, 0, 4'd1, 0, 1, "R4");
    send_beat(32'h12, "R5");
    send_ctl(0, 1, 0, 4'd1, 0, 1, "R5");
    send_beat(32'h13, "R9");
    send_ctl(0, 0, 0, 4'd0, 1, 0, "R9");
    send_ctl(0, 0, 0, 4'd0, 0, 0, "R10");
    send_ctl(0, 1, 1, 4'd2, 0, 0, "R3");
    send_beat(32'h20, "R4");
    send_ctl(1, 0, 0, 4'd0, 1, 1, "R4");
    idle(2);
    send_ctl(0, 1, 1, 4'd4, 0, 0, "R6");
    send_beat(32'h30, "R6");
    send_ctl(0, 0, 0, 4'd0, 1, 0, "R6");
    idle(3);

    // pessimistic
    do_reset(2'd2);
    send_ctl(0, 1, 1, 4'd1, 0, 0, "R3");
    send_beat(32'h40, "R7");
    send_ctl(0, 1, 1, 4'd2, 0, 0, "R7");
    send_beat(32'h50, "R7");
    send_ctl(1, 1, 1, 4'd5, 0, 1, "R7");
    send_beat(32'h60, "R8");
    send_ctl(0, 1, 0, 4'd1, 0, 0, "R8");
    send_beat(32'h41, "R7");
    send_ctl(0, 1, 0, 4'd2, 1, 1, "R7");
    send_beat(32'h51, "R7");
    send_ctl(0, 1, 1, 4'd1, 1, 1, "R7");
    send_beat(32'h42, "R8");
    send_ctl(0, 1, 0, 4'd5, 1, 0, "R8");
    send_beat(32'h61, "R8");
    send_beat(32'h62, "R8");
    send_ctl(0, 0, 0, 4'd0, 1, 0, "R8");
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R2 actual=%0d pending expected=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule